// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between the register interface of a serial-peripheral controller and its shift engine. It keeps two first-in first-out queues of 32-bit words: a transmit queue that the processor fills and the shift engine drains, and a receive queue that the shift engine fills and the processor drains. Around the queues it builds an eight-bit status word, a matching interrupt-enable word and a single interrupt line.

Six status bits are level flags that follow the queue occupancy. Two are sticky: a receive overflow flag, raised when the shift engine pushes a word into a full receive queue, and a transfer-complete flag, raised by a pulse from the shift engine. Both are cleared by writing 1 to their position. A diagnostic word carries both occupancy counters. Each queue has its own flush input, so software can discard pending transmit words without losing received ones, and the other way round.

Top module: `xfer_fifo_status`

## Requirements
- R1: After synchronous reset the status word reads 0x01 (transmit queue empty, all else clear), both occupancy counters read 0, the enable word reads 0 and the interrupt line is low.
- R2: Status bit positions are: 0 transmit empty, 1 transmit half-full (8 or more words), 2 transmit full (16 words), 3 receive ready (1 or more words), 4 receive half-full (8 or more), 5 receive full (16), 6 receive overflow, 7 transfer complete. Bits 0 to 5 are levels that show the occupancy reached at the clock edge that takes the push or pop.
- R3: Each queue holds 16 words of 32 bits and returns them in the order they were pushed; read data of a pop is registered and valid after the edge that takes the pop.
- R4: A processor push into a full transmit queue is ignored: the occupancy stays 16 and the stored words are unchanged.
- R5: A pop from an empty queue returns zero and leaves the occupancy at zero.
- R6: A shift-engine push into a full receive queue discards the word, leaves the occupancy at 16 and sets status bit 6.
- R7: Status bit 6 stays set until a status write with bit 6 at 1; a write with bit 6 at 0 leaves it set.
- R8: A transfer-complete pulse sets status bit 7, which stays set until a status write with bit 7 at 1; when a pulse and a clearing write meet in one cycle, the bit stays set.
- R9: The enable word is loaded by its write strobe and the interrupt line is high exactly when some status bit and the enable bit at the same position are both 1.
- R10: The diagnostic word carries the transmit occupancy in bits 4:0 and the receive occupancy in bits 9:5; the transmit flush empties only the transmit queue and the receive flush only the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_tx_push | input | 1 | Processor write strobe into the transmit queue |
| cpu_tx_data | input | 32 | Word written into the transmit queue |
| cpu_rx_pop | input | 1 | Processor read strobe from the receive queue |
| cpu_rx_data | output | 32 | Word returned by the last receive pop |
| eng_tx_pop | input | 1 | Shift-engine read strobe from the transmit queue |
| eng_tx_data | output | 32 | Word returned by the last transmit pop |
| eng_rx_push | input | 1 | Shift-engine write strobe into the receive queue |
| eng_rx_data | input | 32 | Word written into the receive queue |
| xfer_done | input | 1 | One-cycle transfer-complete pulse |
| flush_tx | input | 1 | Empties the transmit queue |
| flush_rx | input | 1 | Empties the receive queue |
| stat_w1c_we | input | 1 | Status write strobe (write 1 to clear sticky bits) |
| stat_w1c | input | 8 | Status write data |
| ien_we | input | 1 | Enable word write strobe |
| ien_wdata | input | 8 | Enable word write data |
| status | output | 8 | Status word |
| ien | output | 8 | Enable word |
| irq | output | 1 | Masked interrupt line |
| diag | output | 10 | Occupancy counters, receive above transmit |

## Verification
The queues are driven with counting word patterns, so a lost, repeated or reordered word shows up as a wrong value at a known pop, and the threshold flags are read at 1, 7, 8 and 16 words to separate an off-by-one at half-full from one at full. Pushes past full on each side tell the silent drop of the transmit side from the flagged drop of the receive side, and a pop past empty must return zero rather than a stale word. The sticky bits are written with 0, with 1 and with a clear colliding with a set, and the interrupt line is tried with enables that match and that miss the active status bits. Flushing one queue while both hold words shows that the flushes are independent.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  localparam int NFLAG = 8;
  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_HALF  = 1;
  localparam int B_TX_FULL  = 2;
  localparam int B_RX_RDY   = 3;
  localparam int B_RX_HALF  = 4;
  localparam int B_RX_FULL  = 5;
  localparam int B_RX_OVF   = 6;
  localparam int B_DONE     = 7;
endpackage

// File: rtl/xfs_fifo.sv
module xfs_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          dropped
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          accept, take;

  assign accept    = push && (count != FULL_C);
  assign take      = pop && (count != '0);
  assign dropped   = push && !accept;
  assign count_nxt = flush ? '0 : (count + CW'(accept) - CW'(take));

  // storage without reset so a block RAM can hold it
  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        wr_ptr <= wr_ptr + AW'(accept);
        rd_ptr <= rd_ptr + AW'(take);
      end
    end
  end

  // registered read port; an empty pop yields zero
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (pop) rdata <= take ? mem[rd_ptr] : '0;
  end
endmodule

// File: rtl/xfs_flags.sv
module xfs_flags
  import xfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    tx_cnt_nxt,
  input  logic [CW-1:0]    rx_cnt_nxt,
  input  logic             rx_drop,
  input  logic             xfer_done,
  input  logic             w1c_we,
  input  logic [NFLAG-1:0] w1c,
  input  logic             ien_we,
  input  logic [NFLAG-1:0] ien_wdata,
  output logic [NFLAG-1:0] status_q,
  output logic [NFLAG-1:0] ien_q,
  output logic             irq
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic [NFLAG-1:0] status_n;
  logic             clr_ovf, clr_done;

  assign clr_ovf  = w1c_we && w1c[B_RX_OVF];
  assign clr_done = w1c_we && w1c[B_DONE];

  always_comb begin
    status_n             = '0;
    status_n[B_TX_EMPTY] = (tx_cnt_nxt == '0);
    status_n[B_TX_HALF]  = (tx_cnt_nxt >= HALF_C);
    status_n[B_TX_FULL]  = (tx_cnt_nxt == FULL_C);
    status_n[B_RX_RDY]   = (rx_cnt_nxt != '0);
    status_n[B_RX_HALF]  = (rx_cnt_nxt >= HALF_C);
    status_n[B_RX_FULL]  = (rx_cnt_nxt == FULL_C);
    // sticky sources: a new event wins over a clear in the same cycle
    status_n[B_RX_OVF]   = rx_drop   || (status_q[B_RX_OVF] && !clr_ovf);
    status_n[B_DONE]     = xfer_done || (status_q[B_DONE] && !clr_done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= NFLAG'(1) << B_TX_EMPTY;
      ien_q    <= '0;
    end else begin
      status_q <= status_n;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  // AND of two registers, reduced; no path from any input
  assign irq = |(status_q & ien_q);
endmodule

// File: rtl/xfer_fifo_status.sv
module xfer_fifo_status
  import xfs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_tx_push,
  input  logic [DW-1:0]    cpu_tx_data,
  input  logic             cpu_rx_pop,
  output logic [DW-1:0]    cpu_rx_data,
  input  logic             eng_tx_pop,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [DW-1:0]    eng_rx_data,
  input  logic             xfer_done,
  input  logic             flush_tx,
  input  logic             flush_rx,
  input  logic             stat_w1c_we,
  input  logic [NFLAG-1:0] stat_w1c,
  input  logic             ien_we,
  input  logic [NFLAG-1:0] ien_wdata,
  output logic [NFLAG-1:0] status,
  output logic [NFLAG-1:0] ien,
  output logic             irq,
  output logic [2*CW-1:0]  diag
);
  logic [CW-1:0] tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt;
  logic          tx_drop, rx_drop;

  xfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_tx),
    .push(cpu_tx_push), .wdata(cpu_tx_data),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .count(tx_cnt), .count_nxt(tx_cnt_nxt), .dropped(tx_drop)
  );

  xfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_rx),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(cpu_rx_pop), .rdata(cpu_rx_data),
    .count(rx_cnt), .count_nxt(rx_cnt_nxt), .dropped(rx_drop)
  );

  xfs_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst),
    .tx_cnt_nxt(tx_cnt_nxt), .rx_cnt_nxt(rx_cnt_nxt),
    .rx_drop(rx_drop), .xfer_done(xfer_done),
    .w1c_we(stat_w1c_we), .w1c(stat_w1c),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .status_q(status), .ien_q(ien), .irq(irq)
  );

  // a dropped transmit write has no status source: it is silently ignored
  logic unused_tx_drop;
  assign unused_tx_drop = tx_drop;

  assign diag = {rx_cnt, tx_cnt};
endmodule

// File: rtl/xfs_chk.sv
module xfs_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_tx_push,
  input logic            eng_tx_pop,
  input logic            eng_rx_push,
  input logic            flush_tx,
  input logic            xfer_done,
  input logic            stat_w1c_we,
  input logic [7:0]      stat_w1c,
  input logic [7:0]      status,
  input logic [2*CW-1:0] diag
);
  assert_empty_not_full_R2: assert property (@(posedge clk) disable iff (rst)
    !(status[0] && status[2]));

  assert_ready_tracks_count_R2: assert property (@(posedge clk) disable iff (rst)
    status[3] == (diag[2*CW-1:CW] != '0));

  assert_tx_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_tx_push && status[2] && !eng_tx_pop && !flush_tx)
      |=> (diag[CW-1:0] == $past(diag[CW-1:0])));

  assert_overflow_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && status[5]) |=> status[6]);

  assert_done_sets_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> status[7]);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status[7] && !(stat_w1c_we && stat_w1c[7])) |=> status[7]);

  assert_tx_flush_R10: assert property (@(posedge clk) disable iff (rst)
    flush_tx |=> (diag[CW-1:0] == '0));
endmodule

bind xfer_fifo_status xfs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cpu_tx_push(cpu_tx_push), .eng_tx_pop(eng_tx_pop),
  .eng_rx_push(eng_rx_push), .flush_tx(flush_tx), .xfer_done(xfer_done),
  .stat_w1c_we(stat_w1c_we), .stat_w1c(stat_w1c), .status(status), .diag(diag)
);

// File: tb/xfer_fifo_status_tb_top.sv
module xfer_fifo_status_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_tx_push = 0, cpu_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [31:0] cpu_tx_data = 0, eng_rx_data = 0;
  logic [31:0] cpu_rx_data, eng_tx_data;
  logic        xfer_done = 0, flush_tx = 0, flush_rx = 0;
  logic        stat_w1c_we = 0, ien_we = 0;
  logic [7:0]  stat_w1c = 0, ien_wdata = 0;
  logic [7:0]  status, ien;
  logic        irq;
  logic [9:0]  diag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  xfer_fifo_status dut_i (
    .clk(clk), .rst(rst),
    .cpu_tx_push(cpu_tx_push), .cpu_tx_data(cpu_tx_data),
    .cpu_rx_pop(cpu_rx_pop), .cpu_rx_data(cpu_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .xfer_done(xfer_done), .flush_tx(flush_tx), .flush_rx(flush_rx),
    .stat_w1c_we(stat_w1c_we), .stat_w1c(stat_w1c),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .status(status), .ien(ien), .irq(irq), .diag(diag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic tx_write(logic [31:0] w);
    cpu_tx_push = 1; cpu_tx_data = w; tick(); cpu_tx_push = 0;
  endtask
  task automatic tx_drain(output logic [31:0] w);
    eng_tx_pop = 1; tick(); eng_tx_pop = 0; w = eng_tx_data;
  endtask
  task automatic rx_write(logic [31:0] w);
    eng_rx_push = 1; eng_rx_data = w; tick(); eng_rx_push = 0;
  endtask
  task automatic rx_read(output logic [31:0] w);
    cpu_rx_pop = 1; tick(); cpu_rx_pop = 0; w = cpu_rx_data;
  endtask
  task automatic stat_write(logic [7:0] v);
    stat_w1c_we = 1; stat_w1c = v; tick(); stat_w1c_we = 0; stat_w1c = 0;
  endtask
  task automatic ien_write(logic [7:0] v);
    ien_we = 1; ien_wdata = v; tick(); ien_we = 0;
  endtask

  task automatic t_reset();
    check("R1 status", {24'd0, status}, 32'h01);
    check("R1 diag", {22'd0, diag}, 0);
    check("R1 ien", {24'd0, ien}, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_tx_path();
    logic [31:0] w;
    tx_write(32'hA500_0000);
    check("R2 tx one word status", {24'd0, status}, 32'h00);
    check("R10 tx count 1", {22'd0, diag}, 1);
    for (int i = 1; i < 7; i++) tx_write(32'hA500_0000 + i);
    check("R2 tx 7 below half", {31'd0, status[1]}, 0);
    tx_write(32'hA500_0007);
    check("R2 tx 8 half", {24'd0, status}, 32'h02);
    for (int i = 8; i < 16; i++) tx_write(32'hA500_0000 + i);
    check("R2 tx full", {24'd0, status}, 32'h06);
    tx_write(32'hFFFF_FFFF);
    check("R4 tx push when full ignored", {22'd0, diag}, 16);
    for (int i = 0; i < 16; i++) begin
      tx_drain(w);
      check("R3 tx order", w, 32'hA500_0000 + i);
    end
    check("R2 tx empty again", {24'd0, status}, 32'h01);
    tx_drain(w);
    check("R5 tx empty pop data", w, 0);
    check("R5 tx empty pop count", {22'd0, diag}, 0);
  endtask

  task automatic t_rx_path();
    logic [31:0] w;
    rx_write(32'h5A00_0000);
    check("R2 rx ready", {24'd0, status}, 32'h09);
    for (int i = 1; i < 16; i++) rx_write(32'h5A00_0000 + i);
    check("R2 rx full", {24'd0, status}, 32'h39);
    check("R10 rx count field", {22'd0, diag}, 16 << 5);
    rx_write(32'hDEAD_BEEF);
    check("R6 rx overflow flag", {31'd0, status[6]}, 1);
    check("R6 rx count holds", {22'd0, diag}, 16 << 5);
    for (int i = 0; i < 16; i++) begin
      rx_read(w);
      check("R3 rx order", w, 32'h5A00_0000 + i);
    end
    rx_read(w);
    check("R5 rx empty pop data", w, 0);
    check("R5 rx empty status", {24'd0, status}, 32'h41);
    stat_write(8'hBF);
    check("R7 overflow kept on 0 write", {31'd0, status[6]}, 1);
    stat_write(8'h40);
    check("R7 overflow cleared", {24'd0, status}, 32'h01);
  endtask

  task automatic t_done();
    xfer_done = 1; tick(); xfer_done = 0;
    check("R8 done set", {31'd0, status[7]}, 1);
    repeat (3) tick();
    check("R8 done sticky", {31'd0, status[7]}, 1);
    stat_write(8'h7F);
    check("R8 done kept on 0 write", {31'd0, status[7]}, 1);
    xfer_done = 1; stat_w1c_we = 1; stat_w1c = 8'h80; tick();
    xfer_done = 0; stat_w1c_we = 0; stat_w1c = 0;
    check("R8 set wins over clear", {31'd0, status[7]}, 1);
    stat_write(8'h80);
    check("R8 done cleared", {24'd0, status}, 32'h01);
  endtask

  task automatic t_irq();
    ien_write(8'h01);
    check("R9 ien readback", {24'd0, ien}, 32'h01);
    check("R9 irq on tx empty", {31'd0, irq}, 1);
    ien_write(8'h80);
    check("R9 irq masked", {31'd0, irq}, 0);
    xfer_done = 1; tick(); xfer_done = 0;
    check("R9 irq on done", {31'd0, irq}, 1);
    stat_write(8'h80);
    check("R9 irq drops after clear", {31'd0, irq}, 0);
    ien_write(8'h08);
    rx_write(32'h1234_5678);
    check("R9 irq on rx ready", {31'd0, irq}, 1);
    ien_write(8'h00);
  endtask

  task automatic t_flush();
    logic [31:0] w;
    for (int i = 0; i < 5; i++) tx_write(32'hC000_0000 + i);
    for (int i = 0; i < 4; i++) rx_write(32'hD000_0000 + i);
    check("R10 both counts", {22'd0, diag}, (5 << 5) | 5);
    flush_tx = 1; tick(); flush_tx = 0;
    check("R10 tx flush only", {22'd0, diag}, 5 << 5);
    check("R10 tx flush status", {24'd0, status}, 32'h09);
    rx_read(w);
    check("R10 rx intact after tx flush", w, 32'h1234_5678);
    flush_rx = 1; tick(); flush_rx = 0;
    check("R10 rx flush", {22'd0, diag}, 0);
    check("R10 rx flush status", {24'd0, status}, 32'h01);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst = 0;
    tick();
    t_reset();
    t_tx_path();
    t_rx_path();
    t_done();
    t_irq();
    t_flush();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule